// File: doc/BRIEF.md
# I2C Addressed Transfer Sequencer

This block turns one transfer request into the full sequence of bus primitives that a byte-level I2C engine executes: START, STOP, write one byte, read one byte. It runs three kinds of transfer. A presence probe sends a single write-direction device address. A register-addressed write sends the device address, an internal address of zero to `ADDR_BYTES` bytes, and a stream of data bytes. A register-addressed read first sets the device's internal pointer through a write-direction phase, turns the bus around, and then clocks in data bytes. Write data arrives on a valid/ready byte stream and read data leaves on another one. When the transfer ends the block reports a failure flag and how many write data bytes were not acknowledged.

The engine handshake is a one-cycle `eng_go` pulse that carries an operation code, a byte to send and the acknowledge level to drive on a read. The engine answers with a one-cycle `eng_done` that carries the received byte and whether the device answered with NACK. Only one engine operation is outstanding at a time. For memories that keep high address bits in the device address slot, a mask folds the address bits above the stated length into the low bits of the 7-bit device address.

States: `S_IDLE` (accepts a request, goes to `S_START`). `S_START` goes to `S_DEV_R` for a read with no address bytes and to `S_DEV_W` otherwise. `S_DEV_W` goes to `S_STOP` on NACK or for a probe, then to `S_ADDR` when address bytes exist, else onward. `S_ADDR` loops once per address byte and goes to `S_STOP` on NACK. After the address, a write goes to `S_WR_FETCH` (or `S_STOP` if its length is zero) and a read goes to `S_TURN_START` or `S_TURN_STOP`. `S_TURN_STOP` goes to `S_TURN_START`, which goes to `S_DEV_R`. `S_DEV_R` goes to `S_RD_BYTE` or, for length zero, `S_STOP`. `S_RD_BYTE` goes to `S_RD_PUSH`, which goes back to `S_RD_BYTE` or to `S_STOP`. `S_WR_FETCH` goes to `S_WR_BYTE`, which goes back to `S_WR_FETCH` or to `S_STOP`. `S_STOP` goes to `S_DONE`, and `S_DONE` goes to `S_IDLE`.

Top module: `i2c_xfer_seq`

## Requirements
- R1: After reset, and only in the idle state, `req_ready` is 1, while `eng_go`, `resp_valid`, `wr_ready` and `rd_valid` are 0. A request is taken on `req_valid && req_ready`, and `req_ready` is 0 in the following cycle. `req_kind` encodes 0 as probe, 1 as write and 2 as read.
- R2: A probe issues START, then writes `{dev,0}`, then STOP. `resp_fail` is 1 exactly when that byte was NACKed.
- R3: Internal address bytes are written most significant byte first, and their number equals `req_alen` (0 to `ADDR_BYTES`).
- R4: A read with a nonzero address length runs a write-direction phase (`{dev,0}` and the address bytes) before `{dev,1}`. A read with a zero address length writes `{dev,1}` directly after the first START.
- R5: When `cfg_rep_start` is 1, the turnaround into the read phase is a single START. When it is 0, the turnaround is STOP followed by START.
- R6: Every read byte is issued with `eng_nack` 0 except the last, which has `eng_nack` 1. STOP follows the last byte. A read of length zero writes `{dev,1}` and then issues STOP with no read operations.
- R7: If the write-direction device address is NACKed, the next operation is STOP, no further bytes are sent, and `resp_fail` is 1.
- R8: If an internal address byte is NACKed, the next operation is STOP and `resp_fail` is 1.
- R9: On a write, a NACK on a data byte does not stop the transfer. All data bytes are sent, and `resp_nacks` equals the number of NACKed data bytes.
- R10: The device address actually sent is `dev | ((addr >> 8*alen) & cfg_ovf_mask)`. With a zero mask it is `dev` unchanged.
- R11: A write byte is taken only on `wr_valid && wr_ready`, and no write operation is issued while a byte is awaited. While `rd_valid && !rd_ready`, `rd_valid` stays 1 and `rd_data` stays stable.
- R12: `eng_go` is a one-cycle pulse, and the next pulse comes only after `eng_done`. `eng_op` encodes 0 as START, 1 as STOP, 2 as write byte and 3 as read byte.
- R13: The acknowledge of the read-direction address `{dev,1}` is ignored. The read proceeds whatever it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Transfer request present |
| req_ready | output | 1 | Sequencer idle, request taken |
| req_kind | input | 2 | 0 probe, 1 write, 2 read |
| req_dev | input | 7 | 7-bit device address |
| req_addr | input | 8*ADDR_BYTES | Internal address, right-aligned |
| req_alen | input | clog2(ADDR_BYTES+1) | Number of internal address bytes |
| req_len | input | LEN_W | Number of data bytes |
| cfg_rep_start | input | 1 | 1 repeated START turnaround, 0 STOP then START |
| cfg_ovf_mask | input | 7 | Mask for address bits folded into the device address |
| wr_valid | input | 1 | Write byte available |
| wr_ready | output | 1 | Sequencer wants a write byte |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte available |
| rd_ready | input | 1 | Consumer takes read byte |
| rd_data | output | 8 | Read byte |
| eng_go | output | 1 | One-cycle engine command strobe |
| eng_op | output | 2 | Engine operation code |
| eng_wbyte | output | 8 | Byte for a write operation |
| eng_nack | output | 1 | Level to answer a read byte with (1 = NACK) |
| eng_done | input | 1 | Engine finished the operation |
| eng_nacked | input | 1 | Device answered NACK to a written byte |
| eng_rbyte | input | 8 | Byte received by a read operation |
| resp_valid | output | 1 | One-cycle end-of-transfer strobe |
| resp_fail | output | 1 | Transfer failed at device or address phase |
| resp_nacks | output | LEN_W | Count of NACKed write data bytes |

## Verification
A behavioural engine in the bench logs every operation and answers with NACKs chosen per written-byte index, and each logged sequence is compared against a sequence built from the requirements. The probe rows separate present devices from absent ones. The write rows separate an early abort on the device or address byte from data NACKs, which only count. The read rows use zero, one, two and four address bytes under both turnaround settings, which separates a skipped pointer phase from a performed one and a repeated START from a STOP-START. Extra runs fold overflow bits into the device address, NACK the read-direction address, and stall each stream to show that nothing advances until its handshake completes.

// File: rtl/i2cx_pkg.sv
package i2cx_pkg;
    typedef enum logic [1:0] {
        ENG_START = 2'd0,
        ENG_STOP  = 2'd1,
        ENG_WRITE = 2'd2,
        ENG_READ  = 2'd3
    } eng_op_t;

    typedef enum logic [1:0] {
        XFER_PROBE = 2'd0,
        XFER_WRITE = 2'd1,
        XFER_READ  = 2'd2
    } xfer_kind_t;

    typedef enum logic [3:0] {
        S_IDLE, S_START, S_DEV_W, S_ADDR, S_TURN_STOP, S_TURN_START,
        S_DEV_R, S_RD_BYTE, S_RD_PUSH, S_WR_FETCH, S_WR_BYTE, S_STOP, S_DONE
    } seq_state_t;
endpackage

// File: rtl/i2cx_dev_fold.sv
module i2cx_dev_fold #(
    parameter int ADDR_BYTES = 4,
    localparam int AW   = 8 * ADDR_BYTES,
    localparam int AL_W = $clog2(ADDR_BYTES + 1)
) (
    input  logic [6:0]      dev_in,
    input  logic [AW-1:0]   addr,
    input  logic [AL_W-1:0] alen,
    input  logic [6:0]      mask,
    output logic [6:0]      dev_out
);
    logic [AW-1:0] upper;

    // bits above the transmitted address bytes; fully shifted out when alen covers all
    always_comb begin
        upper   = addr >> {alen, 3'b000};
        dev_out = dev_in | (upper[6:0] & mask);
    end
endmodule

// File: rtl/i2cx_byte_pick.sv
module i2cx_byte_pick #(
    parameter int ADDR_BYTES = 4,
    localparam int AW    = 8 * ADDR_BYTES,
    localparam int IDX_W = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1
) (
    input  logic [AW-1:0]    addr,
    input  logic [IDX_W-1:0] idx,
    output logic [7:0]       byte_out
);
    logic [7:0] lanes [ADDR_BYTES];

    for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_lane
        assign lanes[g] = addr[8*g +: 8];
    end

    always_comb begin
        byte_out = 8'h00;
        for (int i = 0; i < ADDR_BYTES; i++) begin
            if (idx == IDX_W'(i)) byte_out = lanes[i];
        end
    end
endmodule

// File: rtl/i2c_xfer_seq.sv
module i2c_xfer_seq
    import i2cx_pkg::*;
#(
    parameter int ADDR_BYTES = 4,
    parameter int LEN_W      = 8,
    localparam int AW    = 8 * ADDR_BYTES,
    localparam int AL_W  = $clog2(ADDR_BYTES + 1),
    localparam int IDX_W = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [1:0]       req_kind,
    input  logic [6:0]       req_dev,
    input  logic [AW-1:0]    req_addr,
    input  logic [AL_W-1:0]  req_alen,
    input  logic [LEN_W-1:0] req_len,
    input  logic             cfg_rep_start,
    input  logic [6:0]       cfg_ovf_mask,
    input  logic             wr_valid,
    output logic             wr_ready,
    input  logic [7:0]       wr_data,
    output logic             rd_valid,
    input  logic             rd_ready,
    output logic [7:0]       rd_data,
    output logic             eng_go,
    output logic [1:0]       eng_op,
    output logic [7:0]       eng_wbyte,
    output logic             eng_nack,
    input  logic             eng_done,
    input  logic             eng_nacked,
    input  logic [7:0]       eng_rbyte,
    output logic             resp_valid,
    output logic             resp_fail,
    output logic [LEN_W-1:0] resp_nacks
);
    seq_state_t       state, nxt, after_addr;
    xfer_kind_t       kind_q;
    logic             issued, done_ok, cmd_st, rep_q;
    logic [AL_W-1:0]  alen_c, alen_q;
    logic [AW-1:0]    addr_q;
    logic [LEN_W-1:0] len_q, nack_q;
    logic [IDX_W-1:0] aidx_q;
    logic [6:0]       dev_fold, dev_q;
    logic [7:0]       wbuf_q, rbuf_q, addr_byte;
    logic             fail_q;

    assign alen_c = (req_alen > AL_W'(ADDR_BYTES)) ? AL_W'(ADDR_BYTES) : req_alen;

    i2cx_dev_fold #(.ADDR_BYTES(ADDR_BYTES)) u_fold (
        .dev_in(req_dev), .addr(req_addr), .alen(alen_c),
        .mask(cfg_ovf_mask), .dev_out(dev_fold)
    );

    i2cx_byte_pick #(.ADDR_BYTES(ADDR_BYTES)) u_pick (
        .addr(addr_q), .idx(aidx_q), .byte_out(addr_byte)
    );

    assign cmd_st  = (state != S_IDLE) && (state != S_RD_PUSH) &&
                     (state != S_WR_FETCH) && (state != S_DONE);
    assign done_ok = issued && eng_done;

    // where the flow goes once the internal address is out
    always_comb begin
        if (kind_q == XFER_WRITE)
            after_addr = (len_q != '0) ? S_WR_FETCH : S_STOP;
        else
            after_addr = rep_q ? S_TURN_START : S_TURN_STOP;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:       if (req_valid) nxt = S_START;
            S_START:      if (done_ok) nxt = (kind_q == XFER_READ && alen_q == '0) ? S_DEV_R : S_DEV_W;
            S_DEV_W:      if (done_ok) begin
                              if (eng_nacked || kind_q == XFER_PROBE) nxt = S_STOP;
                              else if (alen_q != '0)                  nxt = S_ADDR;
                              else                                    nxt = after_addr;
                          end
            S_ADDR:       if (done_ok) begin
                              if (eng_nacked)        nxt = S_STOP;
                              else if (aidx_q == '0) nxt = after_addr;
                          end
            S_TURN_STOP:  if (done_ok) nxt = S_TURN_START;
            S_TURN_START: if (done_ok) nxt = S_DEV_R;
            S_DEV_R:      if (done_ok) nxt = (len_q != '0) ? S_RD_BYTE : S_STOP;
            S_RD_BYTE:    if (done_ok) nxt = S_RD_PUSH;
            S_RD_PUSH:    if (rd_ready) nxt = (len_q == '0) ? S_STOP : S_RD_BYTE;
            S_WR_FETCH:   if (wr_valid) nxt = S_WR_BYTE;
            S_WR_BYTE:    if (done_ok) nxt = (len_q == LEN_W'(1)) ? S_STOP : S_WR_FETCH;
            S_STOP:       if (done_ok) nxt = S_DONE;
            S_DONE:       nxt = S_IDLE;
            default:      nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            issued <= 1'b0;
            kind_q <= XFER_PROBE;
            alen_q <= '0;
            addr_q <= '0;
            len_q  <= '0;
            rep_q  <= 1'b0;
            dev_q  <= '0;
            aidx_q <= '0;
            wbuf_q <= '0;
            rbuf_q <= '0;
            nack_q <= '0;
            fail_q <= 1'b0;
        end else begin
            if (eng_go)       issued <= 1'b1;
            else if (done_ok) issued <= 1'b0;
            unique case (state)
                S_IDLE: if (req_valid) begin
                    kind_q <= (req_kind == 2'd3) ? XFER_PROBE : xfer_kind_t'(req_kind);
                    alen_q <= alen_c;
                    addr_q <= req_addr;
                    len_q  <= req_len;
                    rep_q  <= cfg_rep_start;
                    dev_q  <= dev_fold;
                    aidx_q <= IDX_W'(alen_c - AL_W'(1));
                    nack_q <= '0;
                    fail_q <= 1'b0;
                end
                S_DEV_W: if (done_ok && eng_nacked) fail_q <= 1'b1;
                S_ADDR: if (done_ok) begin
                    if (eng_nacked) fail_q <= 1'b1;
                    else            aidx_q <= aidx_q - IDX_W'(1);
                end
                S_RD_BYTE: if (done_ok) begin
                    rbuf_q <= eng_rbyte;
                    len_q  <= len_q - LEN_W'(1);
                end
                S_WR_FETCH: if (wr_valid) wbuf_q <= wr_data;
                S_WR_BYTE: if (done_ok) begin
                    len_q <= len_q - LEN_W'(1);
                    if (eng_nacked) nack_q <= nack_q + LEN_W'(1);
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        eng_go     = cmd_st && !issued;
        eng_op     = ENG_WRITE;
        eng_wbyte  = 8'h00;
        eng_nack   = 1'b0;
        req_ready  = (state == S_IDLE);
        wr_ready   = (state == S_WR_FETCH);
        rd_valid   = (state == S_RD_PUSH);
        rd_data    = rbuf_q;
        resp_valid = (state == S_DONE);
        resp_fail  = fail_q;
        resp_nacks = nack_q;
        unique case (state)
            S_START, S_TURN_START: eng_op = ENG_START;
            S_STOP, S_TURN_STOP:   eng_op = ENG_STOP;
            S_DEV_W:   eng_wbyte = {dev_q, 1'b0};
            S_DEV_R:   eng_wbyte = {dev_q, 1'b1};
            S_ADDR:    eng_wbyte = addr_byte;
            S_WR_BYTE: eng_wbyte = wbuf_q;
            S_RD_BYTE: begin
                eng_op   = ENG_READ;
                eng_nack = (len_q == LEN_W'(1));
            end
            default: ;
        endcase
    end

    // R12: a command strobe lasts one cycle
    p_go_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        eng_go |=> !eng_go);
    // R1: an accepted request makes the sequencer busy
    p_accept_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
    // R11: a stalled read byte holds
    p_rd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
    // R7: a NACKed device address is followed by STOP
    p_dev_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DEV_W && done_ok && eng_nacked) |=> (eng_go && eng_op == ENG_STOP));
    // R8: a NACKed address byte is followed by STOP
    p_addr_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ADDR && done_ok && eng_nacked) |=> (eng_go && eng_op == ENG_STOP));
    // R11: no write byte is sent while a stream byte is awaited
    p_wait_wr_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ready && !wr_valid) |=> !eng_go);
endmodule

// File: tb/i2c_xfer_seq_tb.sv
module i2c_xfer_seq_tb;
    typedef struct packed {
        logic [3:0]  req;
        logic [1:0]  kind;
        logic [6:0]  dev;
        logic [31:0] addr;
        logic [2:0]  alen;
        logic [7:0]  len;
        logic        rep;
        logic [6:0]  mask;
        logic [15:0] nm;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{4'd2,  2'd0, 7'h50, 32'h0,        3'd0, 8'd0, 1'b0, 7'h00, 16'h0000}, // R2 present
        '{4'd2,  2'd0, 7'h21, 32'h0,        3'd0, 8'd0, 1'b0, 7'h00, 16'h0001}, // R2 absent
        '{4'd3,  2'd1, 7'h50, 32'h1234,     3'd2, 8'd3, 1'b0, 7'h00, 16'h0000}, // R3 msb first
        '{4'd9,  2'd1, 7'h50, 32'h77,       3'd1, 8'd4, 1'b0, 7'h00, 16'h0014}, // R9 two data nacks
        '{4'd7,  2'd1, 7'h44, 32'h0102,     3'd2, 8'd2, 1'b0, 7'h00, 16'h0001}, // R7 dev nack
        '{4'd8,  2'd1, 7'h50, 32'hABCDEF,   3'd3, 8'd2, 1'b0, 7'h00, 16'h0004}, // R8 addr nack
        '{4'd5,  2'd2, 7'h50, 32'h0456,     3'd2, 8'd3, 1'b1, 7'h00, 16'h0000}, // R5 repeated start
        '{4'd5,  2'd2, 7'h3C, 32'h09,       3'd1, 8'd2, 1'b0, 7'h00, 16'h0000}, // R5 stop-start
        '{4'd4,  2'd2, 7'h50, 32'h0,        3'd0, 8'd2, 1'b0, 7'h00, 16'h0000}, // R4 no pointer phase
        '{4'd6,  2'd2, 7'h50, 32'h0011,     3'd2, 8'd0, 1'b1, 7'h00, 16'h0000}, // R6 zero length read
        '{4'd10, 2'd1, 7'h50, 32'h3A5,      3'd1, 8'd1, 1'b0, 7'h07, 16'h0000}, // R10 fold
        '{4'd10, 2'd2, 7'h50, 32'hDEADBEEF, 3'd4, 8'd1, 1'b0, 7'h7F, 16'h0000}, // R10 nothing above
        '{4'd8,  2'd2, 7'h50, 32'h0203,     3'd2, 8'd1, 1'b1, 7'h00, 16'h0002}, // R8 read addr nack
        '{4'd3,  2'd1, 7'h50, 32'h0,        3'd0, 8'd0, 1'b0, 7'h00, 16'h0000}, // R3 zero bytes
        '{4'd13, 2'd2, 7'h50, 32'h0,        3'd0, 8'd1, 1'b0, 7'h00, 16'h0001}  // R13 ignored ack
    };

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        req_valid = 1'b0, req_ready;
    logic [1:0]  req_kind = '0;
    logic [6:0]  req_dev = '0;
    logic [31:0] req_addr = '0;
    logic [2:0]  req_alen = '0;
    logic [7:0]  req_len = '0;
    logic        cfg_rep_start = 1'b0;
    logic [6:0]  cfg_ovf_mask = '0;
    logic        wr_valid = 1'b1, wr_ready;
    logic [7:0]  wr_data;
    logic        rd_valid, rd_ready = 1'b1;
    logic [7:0]  rd_data;
    logic        eng_go, eng_nack, eng_done = 1'b0, eng_nacked = 1'b0;
    logic [1:0]  eng_op;
    logic [7:0]  eng_wbyte, eng_rbyte = '0;
    logic        resp_valid, resp_fail;
    logic [7:0]  resp_nacks;

    always #5 clk = ~clk;

    i2c_xfer_seq u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_dev(req_dev), .req_addr(req_addr), .req_alen(req_alen),
        .req_len(req_len), .cfg_rep_start(cfg_rep_start), .cfg_ovf_mask(cfg_ovf_mask),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
        .eng_go(eng_go), .eng_op(eng_op), .eng_wbyte(eng_wbyte), .eng_nack(eng_nack),
        .eng_done(eng_done), .eng_nacked(eng_nacked), .eng_rbyte(eng_rbyte),
        .resp_valid(resp_valid), .resp_fail(resp_fail), .resp_nacks(resp_nacks)
    );

    int n_chk = 0, n_bad = 0;
    logic [15:0] nm_cur = '0;
    int wr_idx = 0, rd_idx = 0;
    int log_n = 0;
    logic [1:0] log_op [64];
    logic [7:0] log_b  [64];
    logic       log_f  [64];
    int exp_n;
    logic [1:0] exp_op [64];
    logic [7:0] exp_b  [64];
    logic       exp_f  [64];
    logic       exp_fail;
    int         exp_nacks, exp_rd;
    int rd_n = 0;
    logic [7:0] rd_got [64];
    int wr_taken = 0, wr_base = 0;
    logic       got_fail;
    int         got_nacks;

    assign wr_data = 8'h30 + 8'(wr_taken - wr_base);

    always @(posedge clk) if (wr_valid && wr_ready) wr_taken <= wr_taken + 1;

    always @(negedge clk) if (rd_valid && rd_ready && rd_n < 64) begin
        rd_got[rd_n] = rd_data;
        rd_n = rd_n + 1;
    end

    // behavioural byte engine: logs every command and answers after a delay
    initial begin
        forever begin
            @(negedge clk);
            eng_done = 1'b0;
            if (eng_go) begin
                logic nk;
                nk = 1'b0;
                if (log_n < 64) begin
                    log_op[log_n] = eng_op;
                    log_b[log_n]  = eng_wbyte;
                    log_f[log_n]  = eng_nack;
                    log_n = log_n + 1;
                end
                if (eng_op == 2'd2) begin
                    nk = (wr_idx < 16) ? nm_cur[wr_idx] : 1'b0;
                    wr_idx = wr_idx + 1;
                end
                repeat (2) @(negedge clk);
                eng_nacked = nk;
                eng_rbyte  = 8'hC0 + 8'(rd_idx);
                if (eng_op == 2'd3) rd_idx = rd_idx + 1;
                eng_done = 1'b1;
            end
        end
    end

    task automatic chk(input bit ok, input string rq, input string what, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, expv);
        end
    endtask

    task automatic push(input logic [1:0] op, input logic [7:0] b, input logic f);
        exp_op[exp_n] = op; exp_b[exp_n] = b; exp_f[exp_n] = f;
        exp_n++;
    endtask

    // reference sequence built from the requirements
    task automatic ref_model(input vec_t v);
        logic [63:0] up;
        logic [6:0]  d;
        int idx;
        bit nk;
        exp_n = 0; exp_fail = 1'b0; exp_nacks = 0; exp_rd = 0; idx = 0;
        up = {32'h0, v.addr} >> (8 * int'(v.alen));
        d  = v.dev | (up[6:0] & v.mask);
        push(2'd0, 8'h00, 1'b0);
        if (v.kind == 2'd0) begin
            push(2'd2, {d, 1'b0}, 1'b0);
            exp_fail = v.nm[0];
            push(2'd1, 8'h00, 1'b0);
            return;
        end
        if (v.kind == 2'd1 || v.alen != 0) begin
            push(2'd2, {d, 1'b0}, 1'b0);
            nk = v.nm[idx]; idx++;
            if (nk) begin exp_fail = 1'b1; push(2'd1, 8'h00, 1'b0); return; end
            for (int k = int'(v.alen) - 1; k >= 0; k--) begin
                push(2'd2, v.addr[8*k +: 8], 1'b0);
                nk = v.nm[idx]; idx++;
                if (nk) begin exp_fail = 1'b1; push(2'd1, 8'h00, 1'b0); return; end
            end
        end
        if (v.kind == 2'd1) begin
            for (int j = 0; j < int'(v.len); j++) begin
                push(2'd2, 8'h30 + 8'(j), 1'b0);
                if (v.nm[idx]) exp_nacks++;
                idx++;
            end
            push(2'd1, 8'h00, 1'b0);
            return;
        end
        if (v.alen != 0) begin
            if (!v.rep) push(2'd1, 8'h00, 1'b0);
            push(2'd0, 8'h00, 1'b0);
        end
        push(2'd2, {d, 1'b1}, 1'b0);
        for (int j = 0; j < int'(v.len); j++) push(2'd3, 8'h00, (j == int'(v.len) - 1));
        exp_rd = int'(v.len);
        push(2'd1, 8'h00, 1'b0);
    endtask

    task automatic start_req(input vec_t v);
        @(negedge clk);
        nm_cur = v.nm; wr_idx = 0; rd_idx = 0; log_n = 0; rd_n = 0; wr_base = wr_taken;
        req_kind = v.kind; req_dev = v.dev; req_addr = v.addr; req_alen = v.alen;
        req_len = v.len; cfg_rep_start = v.rep; cfg_ovf_mask = v.mask;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_resp(input string rq);
        int t;
        t = 0;
        while (!resp_valid && t < 3000) begin @(negedge clk); t++; end
        chk(resp_valid, rq, "response seen", int'(resp_valid), 1);
        got_fail = resp_fail; got_nacks = int'(resp_nacks);
        @(negedge clk);
    endtask

    task automatic compare(input vec_t v);
        string rq;
        int bad;
        rq = $sformatf("R%0d", v.req);
        chk(log_n == exp_n, rq, "operation count", log_n, exp_n);
        bad = 0;
        for (int i = 0; i < exp_n && i < log_n; i++) begin
            if (log_op[i] != exp_op[i]) bad++;
            else if (exp_op[i] == 2'd2 && log_b[i] != exp_b[i]) bad++;
            else if (exp_op[i] == 2'd3 && log_f[i] != exp_f[i]) bad++;
        end
        chk(bad == 0, rq, "operation mismatches", bad, 0);
        chk(got_fail == exp_fail, rq, "fail flag", int'(got_fail), int'(exp_fail));
        chk(got_nacks == exp_nacks, rq, "data nack count", got_nacks, exp_nacks);
        if (v.kind == 2'd2) begin
            chk(rd_n == exp_rd, rq, "read bytes delivered", rd_n, exp_rd);
            for (int j = 0; j < rd_n && j < exp_rd; j++)
                chk(rd_got[j] == 8'hC0 + 8'(j), rq, "read byte", int'(rd_got[j]), 'hC0 + j);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(req_ready == 1'b1, "R1", "req_ready after reset", int'(req_ready), 1);
        chk(eng_go == 1'b0, "R1", "eng_go after reset", int'(eng_go), 0);
        chk(resp_valid == 1'b0, "R1", "resp_valid after reset", int'(resp_valid), 0);
        chk(wr_ready == 1'b0 && rd_valid == 1'b0, "R1", "streams idle", int'({wr_ready, rd_valid}), 0);

        for (int i = 0; i < NV; i++) begin
            ref_model(VECS[i]);
            start_req(VECS[i]);
            chk(req_ready == 1'b0, "R1", "busy after accept", int'(req_ready), 0);
            wait_resp($sformatf("R%0d", VECS[i].req));
            compare(VECS[i]);
        end

        // R11 read backpressure
        begin
            vec_t v;
            logic [7:0] held;
            int ln;
            v = '{4'd11, 2'd2, 7'h50, 32'h0, 3'd0, 8'd2, 1'b0, 7'h00, 16'h0000};
            ref_model(v);
            rd_ready = 1'b0;
            start_req(v);
            while (!rd_valid) @(negedge clk);
            held = rd_data; ln = log_n;
            repeat (5) @(negedge clk);
            chk(rd_valid == 1'b1 && rd_data == held, "R11", "read byte held", int'(rd_data), int'(held));
            chk(log_n == ln, "R11", "no engine command while stalled", log_n, ln);
            rd_ready = 1'b1;
            wait_resp("R11");
            compare(v);
        end

        // R11 write stream stall
        begin
            vec_t v;
            int ln;
            v = '{4'd11, 2'd1, 7'h50, 32'h0, 3'd0, 8'd2, 1'b0, 7'h00, 16'h0000};
            ref_model(v);
            wr_valid = 1'b0;
            start_req(v);
            while (!wr_ready) @(negedge clk);
            ln = log_n;
            repeat (6) @(negedge clk);
            chk(log_n == ln, "R11", "no write issued without data", log_n, ln);
            chk(wr_taken == wr_base, "R11", "no byte taken without valid", wr_taken - wr_base, 0);
            wr_valid = 1'b1;
            wait_resp("R11");
            compare(v);
        end

        // R12 engine handshake: one command per done (checked over a whole read)
        begin
            vec_t v;
            v = '{4'd12, 2'd2, 7'h50, 32'h0102, 3'd2, 8'd2, 1'b0, 7'h00, 16'h0000};
            ref_model(v);
            start_req(v);
            wait_resp("R12");
            chk(log_n == exp_n, "R12", "one logged command per strobe", log_n, exp_n);
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule